// File: doc/BRIEF.md
# Precise Exception Commit Unit

This unit sits beside a five-stage in-order pipeline (fetch, decode, execute, memory, writeback) and turns faults that are detected anywhere along the way into precise traps. It keeps its own shadow of the decode, execute and memory stage registers. Each slot holds a valid bit, the instruction's PC, a pending-fault flag and a 4-bit cause code. Faults are recorded against the instruction that raised them and carried forward with it. Nothing is reported until that instruction reaches the memory stage, which is the only point where a trap is committed.

The surrounding pipeline feeds the unit the instruction entering from fetch (valid, PC, fetch-address fault) and one detection flag per later stage: illegal opcode in decode, arithmetic overflow in execute and data-address fault in memory. It also feeds an asynchronous interrupt request. When a trap commits, the unit raises kill strobes for fetch, decode, execute and writeback in that same cycle. It drives a redirect to a fixed handler vector and, at the closing clock edge, loads its saved-PC and cause registers. The kill strobes and the redirect are decoded from registered stage state in the same cycle, so the pipeline can squash its own registers at the commit edge. The saved-PC and cause values are registered outputs.

Top module: `exc_commit_unit`

## Requirements
- R1: While `rst` is high and on the first edge after it, `epc_q` and `cause_q` read 0. No kill or redirect is raised until a trap commits.
- R2: A fault is carried with its instruction and is acted on only while that instruction occupies the memory stage. An instruction that enters with a fetch fault therefore raises no redirect for its first three cycles and commits in its fourth.
- R3: For one instruction, the fault from the earliest stage decides the cause. The codes are: fetch-address fault 1, illegal opcode 2, overflow 3, data-address fault 4.
- R4: An asserted `irq_req` commits a trap whenever any instruction is valid in fetch, decode, execute or memory. It overrides any fault and records cause 15.
- R5: In a commit cycle, `kill_f`, `kill_d`, `kill_e`, `kill_wb` and `redirect_valid` are all 1 and `redirect_pc` equals `HANDLER_PC`. In any other cycle all five strobes are 0 and `redirect_pc` is 0.
- R6: On the edge that closes a commit cycle, `cause_q` takes the committed cause and `epc_q` takes the PC of the instruction in memory. In all other cycles both registers hold their value.
- R7: Instructions in fetch, decode and execute during a commit are discarded. Their valid bits clear, so faults they carried or later pick up are never reported.
- R8: An interrupt that arrives with no valid instruction in memory saves the PC of the oldest valid instruction, searched in the order execute, decode, fetch. With no valid instruction anywhere, the interrupt is not taken.
- R9: Detection flags for a stage holding no valid instruction have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| f_valid | input | 1 | An instruction is being fetched this cycle |
| f_pc | input | PC_W | PC of the instruction in fetch |
| f_addr_fault | input | 1 | Fetch-address fault for the instruction in fetch |
| d_illegal_op | input | 1 | Illegal opcode for the instruction in decode |
| e_overflow | input | 1 | Overflow for the instruction in execute |
| m_data_fault | input | 1 | Data-address fault for the instruction in memory |
| irq_req | input | 1 | Pending asynchronous interrupt |
| kill_f | output | 1 | Squash the fetch stage |
| kill_d | output | 1 | Squash the decode stage |
| kill_e | output | 1 | Squash the execute stage |
| kill_wb | output | 1 | Suppress writeback of the instruction leaving memory |
| redirect_valid | output | 1 | Load `redirect_pc` into the fetch PC |
| redirect_pc | output | PC_W | Handler vector when redirecting, else 0 |
| epc_q | output | PC_W | Saved exception PC |
| cause_q | output | 4 | Saved cause code |

## Verification
Two things can meet in one memory-stage cycle: a fault that the instruction has already carried down, or a data fault raised there, and an interrupt that arrives at the same commit point. A fault that reaches memory while a later fault is still in flight behind it is the second such meeting. The bench runs all 32 combinations of the four fault sources and the interrupt on a single instruction as it moves down the pipe. Each time it checks the cause against the priority rule (interrupt, then earliest stage) and checks that the saved PC is that instruction's. A long pseudo-random stream with dense faults makes back-to-back faulting instructions collide. There the bench checks that the younger one is flushed and never reported, and that interrupts over partly empty pipes save the oldest valid PC.

// File: rtl/exc_commit_pkg.sv
package exc_commit_pkg;

  localparam int CAUSE_W = 4;
  localparam int NSTG    = 3;   // tracked slots: decode, execute, memory

  typedef logic [CAUSE_W-1:0] cause_t;

  localparam cause_t CAUSE_NONE  = 4'd0;
  localparam cause_t CAUSE_FETCH = 4'd1;
  localparam cause_t CAUSE_ILLOP = 4'd2;
  localparam cause_t CAUSE_OVF   = 4'd3;
  localparam cause_t CAUSE_DATA  = 4'd4;
  localparam cause_t CAUSE_IRQ   = 4'd15;

  // Code a slot assigns when the stage feeding it flags a fault.
  function automatic cause_t slot_code(input int idx);
    case (idx)
      0:       return CAUSE_FETCH;
      1:       return CAUSE_ILLOP;
      default: return CAUSE_OVF;
    endcase
  endfunction

endpackage

// File: rtl/exc_stage_slot.sv
module exc_stage_slot
  import exc_commit_pkg::*;
#(
  parameter int     PC_W       = 32,
  parameter cause_t LOCAL_CODE = CAUSE_FETCH
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            flush,
  input  logic            in_valid,
  input  logic [PC_W-1:0] in_pc,
  input  logic            in_exc,
  input  cause_t          in_cause,
  input  logic            det,
  output logic            q_valid,
  output logic [PC_W-1:0] q_pc,
  output logic            q_exc,
  output cause_t          q_cause
);

  logic   nxt_exc;
  cause_t nxt_cause;

  // An older (earlier-stage) fault already carried keeps its code.
  always_comb begin
    nxt_exc   = in_valid && (in_exc || det);
    nxt_cause = in_exc ? in_cause : LOCAL_CODE;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      q_valid <= 1'b0;
      q_exc   <= 1'b0;
    end else begin
      q_valid <= in_valid;
      q_exc   <= nxt_exc;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q_pc    <= '0;
      q_cause <= CAUSE_NONE;
    end else begin
      q_pc    <= in_pc;
      q_cause <= nxt_cause;
    end
  end

endmodule

// File: rtl/exc_commit_arb.sv
module exc_commit_arb
  import exc_commit_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic                       f_valid,
  input  logic [PC_W-1:0]            f_pc,
  input  logic [NSTG-1:0]            stg_valid,
  input  logic [NSTG-1:0][PC_W-1:0]  stg_pc,
  input  logic                       m_exc,
  input  cause_t                     m_cause,
  input  logic                       m_data_fault,
  input  logic                       irq_req,
  output logic                       take,
  output cause_t                     take_cause,
  output logic [PC_W-1:0]            take_epc
);

  localparam int MI = NSTG - 1;

  logic            any_live;
  logic            irq_take;
  logic            fault_take;
  logic [PC_W-1:0] oldest_pc;

  // Oldest live PC: memory first, fetch last.
  always_comb begin
    oldest_pc = f_pc;
    for (int i = 0; i < NSTG; i++) begin
      if (stg_valid[i]) oldest_pc = stg_pc[i];
    end
  end

  always_comb begin
    any_live   = f_valid || (|stg_valid);
    irq_take   = irq_req && any_live;
    fault_take = stg_valid[MI] && (m_exc || m_data_fault);
    take       = irq_take || fault_take;
    if (irq_take) begin
      take_cause = CAUSE_IRQ;
      take_epc   = oldest_pc;
    end else begin
      take_cause = m_exc ? m_cause : CAUSE_DATA;
      take_epc   = stg_pc[MI];
    end
  end

endmodule

// File: rtl/exc_arch_regs.sv
module exc_arch_regs
  import exc_commit_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            we,
  input  logic [PC_W-1:0] epc_d,
  input  cause_t          cause_d,
  output logic [PC_W-1:0] epc_q,
  output cause_t          cause_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      epc_q   <= '0;
      cause_q <= CAUSE_NONE;
    end else if (we) begin
      epc_q   <= epc_d;
      cause_q <= cause_d;
    end
  end

endmodule

// File: rtl/exc_commit_unit.sv
module exc_commit_unit
  import exc_commit_pkg::*;
#(
  parameter int              PC_W       = 32,
  parameter logic [PC_W-1:0] HANDLER_PC = 32'h0000_0180
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            f_valid,
  input  logic [PC_W-1:0] f_pc,
  input  logic            f_addr_fault,
  input  logic            d_illegal_op,
  input  logic            e_overflow,
  input  logic            m_data_fault,
  input  logic            irq_req,
  output logic            kill_f,
  output logic            kill_d,
  output logic            kill_e,
  output logic            kill_wb,
  output logic            redirect_valid,
  output logic [PC_W-1:0] redirect_pc,
  output logic [PC_W-1:0] epc_q,
  output logic [3:0]      cause_q
);

  localparam int MI = NSTG - 1;

  logic [NSTG-1:0]           stg_valid;
  logic [NSTG-1:0][PC_W-1:0] stg_pc;
  logic [NSTG-1:0]           stg_exc;
  cause_t [NSTG-1:0]         stg_cause;
  logic [NSTG-1:0]           det_vec;

  logic            take;
  cause_t          take_cause;
  logic [PC_W-1:0] take_epc;
  cause_t          cause_r;

  // Detection flag feeding each slot, ordered fetch, decode, execute.
  assign det_vec = {e_overflow, d_illegal_op, f_addr_fault};

  for (genvar i = 0; i < NSTG; i++) begin : g_slot
    logic            in_v;
    logic [PC_W-1:0] in_p;
    logic            in_x;
    cause_t          in_c;
    if (i == 0) begin : g_head
      assign in_v = f_valid;
      assign in_p = f_pc;
      assign in_x = 1'b0;
      assign in_c = CAUSE_NONE;
    end else begin : g_chain
      assign in_v = stg_valid[i-1];
      assign in_p = stg_pc[i-1];
      assign in_x = stg_exc[i-1];
      assign in_c = stg_cause[i-1];
    end
    exc_stage_slot #(
      .PC_W      (PC_W),
      .LOCAL_CODE(slot_code(i))
    ) u_slot (
      .clk     (clk),
      .rst     (rst),
      .flush   (take),
      .in_valid(in_v),
      .in_pc   (in_p),
      .in_exc  (in_x),
      .in_cause(in_c),
      .det     (det_vec[i]),
      .q_valid (stg_valid[i]),
      .q_pc    (stg_pc[i]),
      .q_exc   (stg_exc[i]),
      .q_cause (stg_cause[i])
    );
  end

  exc_commit_arb #(.PC_W(PC_W)) u_arb (
    .f_valid     (f_valid),
    .f_pc        (f_pc),
    .stg_valid   (stg_valid),
    .stg_pc      (stg_pc),
    .m_exc       (stg_exc[MI]),
    .m_cause     (stg_cause[MI]),
    .m_data_fault(m_data_fault),
    .irq_req     (irq_req),
    .take        (take),
    .take_cause  (take_cause),
    .take_epc    (take_epc)
  );

  exc_arch_regs #(.PC_W(PC_W)) u_regs (
    .clk    (clk),
    .rst    (rst),
    .we     (take),
    .epc_d  (take_epc),
    .cause_d(take_cause),
    .epc_q  (epc_q),
    .cause_q(cause_r)
  );

  assign cause_q        = cause_r;
  assign kill_f         = take;
  assign kill_d         = take;
  assign kill_e         = take;
  assign kill_wb        = take;
  assign redirect_valid = take;
  assign redirect_pc    = take ? HANDLER_PC : '0;

endmodule

// File: rtl/exc_commit_checker.sv
module exc_commit_checker
  import exc_commit_pkg::*;
#(
  parameter int PC_W = 32
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      f_valid,
  input logic                      m_data_fault,
  input logic                      irq_req,
  input logic                      redirect_valid,
  input logic                      kill_wb,
  input logic [PC_W-1:0]           epc_q,
  input logic [3:0]                cause_q,
  input logic [NSTG-1:0]           stg_valid,
  input logic [NSTG-1:0][PC_W-1:0] stg_pc
);

  localparam int MI = NSTG - 1;

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (epc_q == '0) && (cause_q == CAUSE_NONE));

  p_fault_commits_r2: assert property (@(posedge clk) disable iff (rst)
    (stg_valid[MI] && m_data_fault) |-> (redirect_valid && kill_wb));

  p_irq_takes_r4: assert property (@(posedge clk) disable iff (rst)
    (irq_req && stg_valid[MI]) |-> redirect_valid);

  p_irq_cause_r4: assert property (@(posedge clk) disable iff (rst)
    (redirect_valid && irq_req) |=> (cause_q == CAUSE_IRQ));

  p_epc_from_mem_r6: assert property (@(posedge clk) disable iff (rst)
    (redirect_valid && stg_valid[MI]) |=> (epc_q == $past(stg_pc[MI])));

  p_hold_regs_r6: assert property (@(posedge clk) disable iff (rst)
    !redirect_valid |=> ($stable(epc_q) && $stable(cause_q)));

  p_flush_slots_r7: assert property (@(posedge clk) disable iff (rst)
    redirect_valid |=> (stg_valid == '0));

  p_idle_irq_r8: assert property (@(posedge clk) disable iff (rst)
    (irq_req && (stg_valid == '0) && !f_valid) |-> !redirect_valid);

endmodule

bind exc_commit_unit exc_commit_checker #(.PC_W(PC_W)) i_chk (
  .clk           (clk),
  .rst           (rst),
  .f_valid       (f_valid),
  .m_data_fault  (m_data_fault),
  .irq_req       (irq_req),
  .redirect_valid(redirect_valid),
  .kill_wb       (kill_wb),
  .epc_q         (epc_q),
  .cause_q       (cause_q),
  .stg_valid     (stg_valid),
  .stg_pc        (stg_pc)
);

// File: tb/test_exc_commit_unit.sv
module test_exc_commit_unit;

  localparam int          PC_W    = 32;
  localparam logic [31:0] HANDLER = 32'h0000_0180;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        f_valid = 1'b0;
  logic [31:0] f_pc = '0;
  logic        f_addr_fault = 1'b0;
  logic        d_illegal_op = 1'b0;
  logic        e_overflow = 1'b0;
  logic        m_data_fault = 1'b0;
  logic        irq_req = 1'b0;
  logic        kill_f, kill_d, kill_e, kill_wb, redirect_valid;
  logic [31:0] redirect_pc, epc_q;
  logic [3:0]  cause_q;

  int n_chk  = 0;
  int n_fail = 0;

  // Bench model of the tracked slots: 0 decode, 1 execute, 2 memory.
  logic        mv [3];
  logic [31:0] mpc[3];
  logic        mx [3];
  logic [3:0]  mc [3];
  logic [31:0] m_epc;
  logic [3:0]  m_cause;
  logic        last_take;

  always #5 clk = ~clk;

  exc_commit_unit #(.PC_W(PC_W), .HANDLER_PC(HANDLER)) i_exc_commit_unit (
    .clk(clk), .rst(rst), .f_valid(f_valid), .f_pc(f_pc),
    .f_addr_fault(f_addr_fault), .d_illegal_op(d_illegal_op),
    .e_overflow(e_overflow), .m_data_fault(m_data_fault), .irq_req(irq_req),
    .kill_f(kill_f), .kill_d(kill_d), .kill_e(kill_e), .kill_wb(kill_wb),
    .redirect_valid(redirect_valid), .redirect_pc(redirect_pc),
    .epc_q(epc_q), .cause_q(cause_q)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int i = 0; i < 3; i++) begin
      mv[i] = 1'b0; mx[i] = 1'b0; mpc[i] = '0; mc[i] = '0;
    end
  endtask

  // One cycle: drive at the falling edge, judge before the rising edge, then advance the model.
  task automatic step(input logic fv, input logic [31:0] fpc, input logic ff,
                      input logic di, input logic eo, input logic md, input logic irq);
    logic        any, mexc, irq_ok, tk;
    logic [3:0]  ec;
    logic [31:0] ep;
    @(negedge clk);
    f_valid = fv; f_pc = fpc; f_addr_fault = ff; d_illegal_op = di;
    e_overflow = eo; m_data_fault = md; irq_req = irq;
    #3;
    any    = fv | mv[0] | mv[1] | mv[2];
    mexc   = mv[2] && (mx[2] || md);
    irq_ok = irq && any;
    tk     = mexc || irq_ok;
    ec     = irq_ok ? 4'd15 : (mx[2] ? mc[2] : 4'd4);
    ep     = irq_ok ? (mv[2] ? mpc[2] : mv[1] ? mpc[1] : mv[0] ? mpc[0] : fpc) : mpc[2];
    chk("R5 kill_f", {31'd0, kill_f}, {31'd0, tk});
    chk("R5 kill_d", {31'd0, kill_d}, {31'd0, tk});
    chk("R5 kill_e", {31'd0, kill_e}, {31'd0, tk});
    chk("R5 kill_wb", {31'd0, kill_wb}, {31'd0, tk});
    chk("R5 redirect_valid", {31'd0, redirect_valid}, {31'd0, tk});
    chk("R5 redirect_pc", redirect_pc, tk ? HANDLER : 32'd0);
    chk("R6 epc_q", epc_q, m_epc);
    chk("R6 cause_q", {28'd0, cause_q}, {28'd0, m_cause});
    last_take = tk;
    @(posedge clk);
    if (tk) begin
      m_epc = ep; m_cause = ec;
      model_clear();
    end else begin
      mv[2] = mv[1]; mpc[2] = mpc[1]; mx[2] = mv[1] && (mx[1] || eo); mc[2] = mx[1] ? mc[1] : 4'd3;
      mv[1] = mv[0]; mpc[1] = mpc[0]; mx[1] = mv[0] && (mx[0] || di); mc[1] = mx[0] ? mc[0] : 4'd2;
      mv[0] = fv;    mpc[0] = fpc;    mx[0] = fv && ff;               mc[0] = 4'd1;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 32'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  initial begin : watchdog
    #1_500_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : stim
    logic [31:0] lfsr;
    model_clear();
    m_epc = '0; m_cause = '0; last_take = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 epc_q in reset", epc_q, 32'd0);
    chk("R1 cause_q in reset", {28'd0, cause_q}, 32'd0);
    chk("R1 redirect in reset", {31'd0, redirect_valid}, 32'd0);
    @(negedge clk);
    rst = 1'b0;
    idle(2);

    // R2 R3 R4: every combination of the four fault sources plus interrupt on one instruction.
    for (int p = 0; p < 32; p++) begin
      logic [31:0] pc;
      logic [3:0]  exp_c;
      pc = 32'h0000_1000 + 32'(p) * 32'h40;
      exp_c = p[4] ? 4'd15 : p[0] ? 4'd1 : p[1] ? 4'd2 : p[2] ? 4'd3 : p[3] ? 4'd4 : 4'd0;
      step(1'b1, pc, p[0], 1'b0, 1'b0, 1'b0, 1'b0);
      chk("R2 no commit in fetch", {31'd0, redirect_valid}, 32'd0);
      step(1'b0, 32'd0, 1'b0, p[1], 1'b0, 1'b0, 1'b0);
      chk("R2 no commit in decode", {31'd0, redirect_valid}, 32'd0);
      step(1'b0, 32'd0, 1'b0, 1'b0, p[2], 1'b0, 1'b0);
      chk("R2 no commit in execute", {31'd0, redirect_valid}, 32'd0);
      step(1'b0, 32'd0, 1'b0, 1'b0, 1'b0, p[3], p[4]);
      chk("R2 commit at memory", {31'd0, redirect_valid}, {31'd0, (exp_c != 4'd0)});
      idle(1);
      if (exp_c != 4'd0) begin
        chk(p[4] ? "R4 interrupt cause" : "R3 earliest-stage cause", {28'd0, cause_q}, {28'd0, exp_c});
        chk("R6 saved pc of faulting instruction", epc_q, pc);
      end
    end

    // R7: overflow on A, fetch fault on B right behind; B must never be reported.
    step(1'b1, 32'h0000_2000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    step(1'b1, 32'h0000_2004, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    step(1'b0, 32'd0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
    step(1'b0, 32'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R7 older overflow commits", {31'd0, last_take}, 32'd1);
    step(1'b0, 32'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    chk("R7 flushed fault not reported", {31'd0, redirect_valid}, 32'd0);
    chk("R7 cause from older instruction", {28'd0, cause_q}, 32'd3);
    chk("R7 pc of older instruction", epc_q, 32'h0000_2000);
    idle(2);

    // R8: interrupt with memory empty picks the oldest live PC; none live means no trap.
    step(1'b1, 32'h0000_3000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    step(1'b1, 32'h0000_3004, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    step(1'b1, 32'h0000_3008, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    idle(1);
    chk("R8 epc is oldest live pc", epc_q, 32'h0000_3000);
    step(1'b1, 32'h0000_3100, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    idle(1);
    chk("R8 epc from fetch when pipe empty", epc_q, 32'h0000_3100);
    step(1'b0, 32'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    chk("R8 interrupt with nothing live ignored", {31'd0, redirect_valid}, 32'd0);

    // R9: detection flags on empty stages.
    step(1'b0, 32'd0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0);
    chk("R9 flags on empty stages ignored", {31'd0, redirect_valid}, 32'd0);
    idle(3);
    chk("R9 no late trap from empty stages", {28'd0, cause_q}, 32'd15);

    // Pseudo-random stream with dense faults, judged by the model every cycle (R3 R5 R6 R7 R8 R9).
    lfsr = 32'hACE1_1234;
    for (int c = 0; c < 4000; c++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      step(lfsr[0] | lfsr[1], {16'h0, lfsr[17:4], 2'b00},
           lfsr[5] & lfsr[9] & lfsr[13],
           lfsr[6] & lfsr[10] & lfsr[14],
           lfsr[7] & lfsr[11] & lfsr[15],
           lfsr[8] & lfsr[12] & lfsr[16],
           lfsr[20] & lfsr[24] & lfsr[28] & lfsr[30]);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule